// File: doc/BRIEF.md
# TDM PCM Frame Serializer

This block is one station on a time-division-multiplexed PCM serial link. It derives a bit clock from the system clock with a fixed divider. It generates a frame sync once per sample period. It places its own parallel transmit word into an assigned time slot on the outbound data line, and it extracts the word sent in the same slot on the inbound line. Other stations share the outbound line. Outside its own slot the block drops its output enable, so a pad-level tri-state buffer releases the line.

A frame holds `slot_cnt_i` slots of `slot_w_i` bit clocks each. The station occupies slot `slot_idx_i`. Two sync alignments can be selected. With delayed sync, the sync pulse covers the last bit period of the previous frame, and the MSB of slot 0 launches on the falling bit-clock edge that ends the pulse. With aligned sync, the MSB of slot 0 launches together with the rising edge of sync. All configuration and the transmit word are captured when a frame starts, so changes made during a frame take effect on the next frame.

Top module: `pcm_tdm_port`

## Requirements
- R1: After reset, `bclk_o`, `sync_o`, `tx_o`, `tx_oe_o` and `rx_valid_o` are low. `bclk_o` then toggles every `HALF_DIV` system clocks, and its first transition is a rise.
- R2: A frame lasts `slot_cnt_i * slot_w_i` bit periods, and the first frame starts at the first falling edge of `bclk_o`. `sync_o` is high for exactly one bit period per frame. Every output except `rx_data_o`/`rx_valid_o` changes only at falling bit-clock edges.
- R3: With `mode_i` = 1 (aligned sync), `sync_o` is high during bit period 0 of the frame, which is the MSB period of slot 0.
- R4: With `mode_i` = 0 (delayed sync), `sync_o` is high during the last bit period of each frame. Slot 0's MSB starts at the falling edge that ends the pulse.
- R5: `tx_oe_o` is high exactly during bit periods `slot_idx_i*slot_w_i` through `slot_idx_i*slot_w_i + slot_w_i - 1` of the frame, and it is low in all other periods.
- R6: Inside the own slot, `tx_o` carries the captured transmit word MSB first in the first `DATA_W` bit periods, then 0 for any remaining periods. `tx_data_i` is captured at the falling edge that starts the frame.
- R7: `rx_i` is sampled on rising bit-clock edges during the first `DATA_W` bit periods of the own slot. It is assembled MSB first into `rx_data_o`.
- R8: `rx_valid_o` is a one-system-clock pulse, once per frame. It rises in the clock after the rising bit-clock edge of the last bit of the own slot, and it stays low at all other times.
- R9: Changes to `mode_i`, `slot_cnt_i`, `slot_w_i` and `slot_idx_i` during a frame have no effect on that frame.
- R10: `tx_o` is low whenever `tx_oe_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 1 | Sync alignment: 0 delayed, 1 aligned |
| slot_cnt_i | input | SC_W | Slots per frame, 1..MAX_SLOTS |
| slot_w_i | input | SW_W | Bit clocks per slot, DATA_W..MAX_SW |
| slot_idx_i | input | IDX_W | Own slot index, below slot_cnt_i |
| tx_data_i | input | DATA_W | Word to transmit in the next frame |
| rx_i | input | 1 | Inbound serial data |
| bclk_o | output | 1 | Bit clock |
| sync_o | output | 1 | Frame sync, one bit clock wide |
| tx_o | output | 1 | Outbound serial data |
| tx_oe_o | output | 1 | Outbound driver enable, own slot only |
| rx_data_o | output | DATA_W | Last word received in the own slot |
| rx_valid_o | output | 1 | One-clock strobe for a new rx_data_o |

## Verification
The assertions assume that the configuration presented at each frame start is legal. That means a slot count from 1 to MAX_SLOTS, a slot width from DATA_W to MAX_SW, and a slot index below the slot count. One assertion checks exactly this at the frame boundary. The stimulus uses only legal configurations, including the single-slot frame, the last slot of a frame, the largest frame and slots padded beyond the word width. Stimulus only ever replaces one legal setting with another. This applies to the decoy settings written mid-frame to exercise R9 as well. The inbound line is driven only at falling bit-clock edges, so it is stable at every sampling edge. Outside the own slot it is filled with random bits.

// File: rtl/pcm_tdm_pkg.sv
package pcm_tdm_pkg;
  typedef enum logic {
    SYNC_DELAYED = 1'b0,
    SYNC_ALIGNED = 1'b1
  } sync_mode_e;
endpackage

// File: rtl/pcm_bclk_div.sv
module pcm_bclk_div #(
  parameter int HALF_DIV = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic bclk_o,
  output logic rise_o,
  output logic fall_o
);
  localparam int DIV_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(HALF_DIV - 1);

  logic [DIV_W-1:0] div_q;
  logic             bclk_q;
  logic             edge_w;

  assign edge_w = (div_q == DIV_LAST);
  assign rise_o = edge_w && !bclk_q;
  assign fall_o = edge_w && bclk_q;
  assign bclk_o = bclk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q  <= '0;
      bclk_q <= 1'b0;
    end else if (edge_w) begin
      div_q  <= '0;
      bclk_q <= !bclk_q;
    end else begin
      div_q  <= div_q + 1'b1;
    end
  end

  assert_bclk_follows_rise_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> bclk_o);
endmodule

// File: rtl/pcm_frame_ctl.sv
module pcm_frame_ctl
  import pcm_tdm_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int MAX_SLOTS = 8,
  parameter int MAX_SW    = 32,
  parameter int SC_W      = 4,
  parameter int SW_W      = 6,
  parameter int IDX_W     = 3,
  parameter int POS_W     = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fall_i,
  input  logic             mode_i,
  input  logic [SC_W-1:0]  slot_cnt_i,
  input  logic [SW_W-1:0]  slot_w_i,
  input  logic [IDX_W-1:0] slot_idx_i,
  output logic             wrap_o,
  output logic             sync_o,
  output logic             in_slot_o,
  output logic             last_bit_o,
  output logic [POS_W-1:0] bit_idx_o
);
  localparam int PW = SC_W + SW_W + IDX_W;

  logic             run_q;
  logic [POS_W-1:0] pos_q, last_q, start_q, end_q;
  sync_mode_e       mode_q;
  logic             wrap_w;
  logic [PW-1:0]    len_w, start_w;

  assign wrap_w  = !run_q || (pos_q == last_q);
  assign len_w   = PW'(slot_cnt_i) * PW'(slot_w_i);
  assign start_w = PW'(slot_idx_i) * PW'(slot_w_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q   <= 1'b0;
      pos_q   <= '0;
      last_q  <= '0;
      start_q <= '0;
      end_q   <= '0;
      mode_q  <= SYNC_DELAYED;
    end else if (fall_i) begin
      if (wrap_w) begin
        run_q   <= 1'b1;
        pos_q   <= '0;
        last_q  <= POS_W'(len_w - PW'(1));
        start_q <= POS_W'(start_w);
        end_q   <= POS_W'(start_w + PW'(slot_w_i) - PW'(1));
        mode_q  <= sync_mode_e'(mode_i);
      end else begin
        pos_q <= pos_q + 1'b1;
      end
    end
  end

  assign wrap_o     = fall_i && wrap_w;
  assign sync_o     = run_q && ((mode_q == SYNC_ALIGNED) ? (pos_q == '0) : (pos_q == last_q));
  assign in_slot_o  = run_q && (pos_q >= start_q) && (pos_q <= end_q);
  assign last_bit_o = in_slot_o && (pos_q == end_q);
  assign bit_idx_o  = pos_q - start_q;

  assert_pos_in_frame_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q |-> (pos_q <= last_q));
  assert_pos_holds_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fall_i |=> $stable(pos_q));
  assert_cfg_legal_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fall_i && wrap_w) |-> (slot_cnt_i != '0) && (int'(slot_cnt_i) <= MAX_SLOTS) &&
      (int'(slot_w_i) >= DATA_W) && (int'(slot_w_i) <= MAX_SW) &&
      (PW'(slot_idx_i) < PW'(slot_cnt_i)));
endmodule

// File: rtl/pcm_slot_tx.sv
module pcm_slot_tx #(
  parameter int DATA_W = 16,
  parameter int POS_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] tx_data_i,
  input  logic              in_slot_i,
  input  logic [POS_W-1:0]  bit_idx_i,
  output logic              tx_o,
  output logic              tx_oe_o
);
  localparam int DW_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;

  logic [DATA_W-1:0] word_q;
  logic [DW_W-1:0]   sel_w;
  logic              payload_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     word_q <= '0;
    else if (load_i) word_q <= tx_data_i;
  end

  assign payload_w = bit_idx_i < POS_W'(DATA_W);
  assign sel_w     = DW_W'(DATA_W - 1) - bit_idx_i[DW_W-1:0];
  assign tx_oe_o   = in_slot_i;
  // pad bits past the word are driven 0
  assign tx_o      = in_slot_i && payload_w && word_q[sel_w];
endmodule

// File: rtl/pcm_slot_rx.sv
module pcm_slot_rx #(
  parameter int DATA_W = 16,
  parameter int POS_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rise_i,
  input  logic              in_slot_i,
  input  logic              last_bit_i,
  input  logic [POS_W-1:0]  bit_idx_i,
  input  logic              rx_i,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rx_valid_o
);
  logic [DATA_W-1:0] sh_q;
  logic [DATA_W-1:0] sh_nxt;
  logic              take_w;

  assign take_w = rise_i && in_slot_i && (bit_idx_i < POS_W'(DATA_W));
  assign sh_nxt = take_w ? {sh_q[DATA_W-2:0], rx_i} : sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q       <= '0;
      rx_data_o  <= '0;
      rx_valid_o <= 1'b0;
    end else begin
      sh_q       <= sh_nxt;
      rx_valid_o <= 1'b0;
      if (rise_i && last_bit_i) begin
        rx_data_o  <= sh_nxt;
        rx_valid_o <= 1'b1;
      end
    end
  end

  assert_valid_single_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |=> !rx_valid_o);
endmodule

// File: rtl/pcm_tdm_port.sv
module pcm_tdm_port #(
  parameter int DATA_W    = 16,
  parameter int MAX_SLOTS = 8,
  parameter int MAX_SW    = 32,
  parameter int HALF_DIV  = 2,
  parameter int SC_W      = $clog2(MAX_SLOTS + 1),
  parameter int SW_W      = $clog2(MAX_SW + 1),
  parameter int IDX_W     = (MAX_SLOTS > 1) ? $clog2(MAX_SLOTS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_i,
  input  logic [SC_W-1:0]   slot_cnt_i,
  input  logic [SW_W-1:0]   slot_w_i,
  input  logic [IDX_W-1:0]  slot_idx_i,
  input  logic [DATA_W-1:0] tx_data_i,
  input  logic              rx_i,
  output logic              bclk_o,
  output logic              sync_o,
  output logic              tx_o,
  output logic              tx_oe_o,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rx_valid_o
);
  localparam int POS_W = $clog2(MAX_SLOTS * MAX_SW);

  logic             rise_w, fall_w, wrap_w, in_slot_w, last_bit_w;
  logic [POS_W-1:0] bit_idx_w;

  pcm_bclk_div #(.HALF_DIV(HALF_DIV)) i_div (
    .clk_i, .rst_ni, .bclk_o, .rise_o(rise_w), .fall_o(fall_w)
  );

  pcm_frame_ctl #(
    .DATA_W(DATA_W), .MAX_SLOTS(MAX_SLOTS), .MAX_SW(MAX_SW),
    .SC_W(SC_W), .SW_W(SW_W), .IDX_W(IDX_W), .POS_W(POS_W)
  ) i_frame (
    .clk_i, .rst_ni, .fall_i(fall_w), .mode_i, .slot_cnt_i, .slot_w_i, .slot_idx_i,
    .wrap_o(wrap_w), .sync_o, .in_slot_o(in_slot_w), .last_bit_o(last_bit_w),
    .bit_idx_o(bit_idx_w)
  );

  pcm_slot_tx #(.DATA_W(DATA_W), .POS_W(POS_W)) i_tx (
    .clk_i, .rst_ni, .load_i(wrap_w), .tx_data_i, .in_slot_i(in_slot_w),
    .bit_idx_i(bit_idx_w), .tx_o, .tx_oe_o
  );

  pcm_slot_rx #(.DATA_W(DATA_W), .POS_W(POS_W)) i_rx (
    .clk_i, .rst_ni, .rise_i(rise_w), .in_slot_i(in_slot_w), .last_bit_i(last_bit_w),
    .bit_idx_i(bit_idx_w), .rx_i, .rx_data_o, .rx_valid_o
  );

  assert_launch_on_fall_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fall_w |=> ($stable(tx_o) && $stable(tx_oe_o) && $stable(sync_o)));
  assert_valid_after_rise_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |-> $past(rise_w));
endmodule

// File: tb/test_pcm_tdm_port.sv
`timescale 1ns/1ps
module test_pcm_tdm_port;
  localparam int DATA_W = 16, MAX_SLOTS = 8, MAX_SW = 32, HALF_DIV = 2;
  localparam int SC_W = 4, SW_W = 6, IDX_W = 3;

  typedef struct {
    logic mode; int cnt; int w; int idx;
    logic [DATA_W-1:0] txw; logic [DATA_W-1:0] rxw;
  } frame_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode_i = 1'b0;
  logic [SC_W-1:0] slot_cnt_i = '0;
  logic [SW_W-1:0] slot_w_i = '0;
  logic [IDX_W-1:0] slot_idx_i = '0;
  logic [DATA_W-1:0] tx_data_i = '0;
  logic rx_i = 1'b0;
  logic bclk_o, sync_o, tx_o, tx_oe_o, rx_valid_o;
  logic [DATA_W-1:0] rx_data_o;

  always #2.5 clk = ~clk;

  pcm_tdm_port #(.DATA_W(DATA_W), .MAX_SLOTS(MAX_SLOTS), .MAX_SW(MAX_SW), .HALF_DIV(HALF_DIV))
  i_pcm_tdm_port (
    .clk_i(clk), .rst_ni(rst_n), .mode_i, .slot_cnt_i, .slot_w_i, .slot_idx_i,
    .tx_data_i, .rx_i, .bclk_o, .sync_o, .tx_o, .tx_oe_o, .rx_data_o, .rx_valid_o
  );

  int checks = 0, errors = 0;
  bit done = 0, finished = 0;
  event frame_start_ev;
  frame_t sb_q[$];

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic drive_frame(input frame_t f);
    mode_i     = f.mode;
    slot_cnt_i = SC_W'(f.cnt);
    slot_w_i   = SW_W'(f.w);
    slot_idx_i = IDX_W'(f.idx);
    tx_data_i  = f.txw;
    sb_q.push_back(f);
  endtask

  task automatic send_frame(input frame_t f);
    @(frame_start_ev);
    drive_frame(f);
  endtask

  // R9: decoy settings written during a running frame must not disturb it
  task automatic send_frame_late(input frame_t f, input frame_t decoy);
    @(frame_start_ev);
    mode_i     = decoy.mode;
    slot_cnt_i = SC_W'(decoy.cnt);
    slot_w_i   = SW_W'(decoy.w);
    slot_idx_i = IDX_W'(decoy.idx);
    tx_data_i  = decoy.txw;
    repeat (24) @(negedge clk);
    drive_frame(f);
  endtask

  function automatic frame_t mk(input logic m, input int c, input int w, input int x, input int n);
    frame_t f;
    f.mode = m; f.cnt = c; f.w = w; f.idx = x;
    f.txw = DATA_W'(16'hA5C3 ^ (n * 16'h1357));
    f.rxw = DATA_W'(16'h3C96 ^ (n * 16'h2F1B));
    return f;
  endfunction

  // monitor / scoreboard
  int pos = 0, hc = 0, b;
  bit running = 0, in_slot, exp_sync, exp_tx, exp_v;
  frame_t cur;
  logic prev_bclk = 1'b0;

  always @(negedge clk) begin
    if (!rst_n) begin
      prev_bclk = 1'b0; running = 0; pos = 0; hc = 0;
    end else if (!done) begin
      hc++;
      if (bclk_o !== prev_bclk) begin
        check("R1 bclk half period", hc, HALF_DIV);
        hc = 0;
      end
      if (prev_bclk && !bclk_o) begin
        if (!running || pos == cur.cnt * cur.w - 1) begin
          if (sb_q.size() == 0) done = 1;
          else begin
            cur = sb_q.pop_front();
            pos = 0; running = 1;
            -> frame_start_ev;
          end
        end else pos++;
        if (!done) begin
          in_slot  = (pos >= cur.idx * cur.w) && (pos < (cur.idx + 1) * cur.w);
          b        = pos - cur.idx * cur.w;
          exp_sync = cur.mode ? (pos == 0) : (pos == cur.cnt * cur.w - 1);
          check(cur.mode ? "R2 R3 sync" : "R2 R4 sync", sync_o, exp_sync);
          check("R5 oe", tx_oe_o, in_slot);
          exp_tx = (in_slot && b < DATA_W) ? cur.txw[DATA_W-1-b] : 1'b0;
          check(in_slot ? "R6 tx bit" : "R10 tx idle", tx_o, exp_tx);
          rx_i = (in_slot && b < DATA_W) ? cur.rxw[DATA_W-1-b] : 1'($urandom % 2);
        end
      end else if (!prev_bclk && bclk_o) begin
        exp_v = running && (pos == (cur.idx + 1) * cur.w - 1);
        check("R8 valid strobe", rx_valid_o, exp_v);
        if (exp_v) check("R7 rx word", rx_data_o, cur.rxw);
      end else begin
        check("R8 no strobe", rx_valid_o, 1'b0);
      end
      prev_bclk = bclk_o;
    end
  end

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    summary();
  end

  initial begin
    drive_frame(mk(1'b1, 4, 16, 1, 0));
    repeat (3) @(negedge clk);
    check("R1 reset bclk", bclk_o, 1'b0);
    check("R1 reset sync", sync_o, 1'b0);
    check("R1 reset oe", tx_oe_o, 1'b0);
    check("R1 reset tx", tx_o, 1'b0);
    check("R1 reset valid", rx_valid_o, 1'b0);
    #1 rst_n = 1'b1;
    send_frame(mk(1'b1, 4, 16, 1, 1));
    send_frame(mk(1'b0, 4, 16, 0, 2));
    send_frame(mk(1'b0, 4, 16, 0, 3));
    send_frame(mk(1'b1, 3, 20, 2, 4));
    send_frame(mk(1'b1, 3, 20, 2, 5));
    send_frame(mk(1'b0, 8, 16, 7, 6));
    send_frame(mk(1'b0, 8, 32, 3, 7));
    send_frame_late(mk(1'b1, 1, 16, 0, 8), mk(1'b0, 2, 16, 1, 20));
    send_frame(mk(1'b1, 1, 16, 0, 9));
    send_frame_late(mk(1'b0, 2, 24, 1, 10), mk(1'b1, 8, 32, 5, 21));
    send_frame(mk(1'b0, 2, 24, 1, 11));
    wait (done);
    repeat (4) @(negedge clk);
    summary();
  end
endmodule